// File: doc/BRIEF.md
# Register-Mapped GPIO Pin Controller

This block gives software control over a bank of general-purpose pins through a flat 32-bit register space. Each pin owns a pair of configuration words. The first holds the output level, the direction, the choice between GPIO and the pin's native function, and a read-only copy of the synchronized input level. The second holds an input-sense disable and a two-bit weak-pull selection that goes to the pad. A separate ownership bitmap, packed 32 pins per word, arrives as a preset input. Only pins marked as owned may drive their pads.

Software reads and writes through a simple bus with an address, a write enable, write data and registered read data. The block drives each pin's output level, output enable and pull code. It samples each pin's input through a two-flop synchronizer. One global control bit selects which of two interrupt lines a downstream interrupt block uses. Edge and level detection are not part of this block.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset, every first configuration word reads 0x00000005 (input, GPIO mode, output level 0). Every second configuration word reads 0x00000004 (sensing off, pull code 0). The global control word reads 0. pin_out, pin_oe and irq_line_sel are all 0.
- R2: The ownership bitmap reads at byte addresses 0x00, 0x04 and 0x08. Bit b of word w reports own_map for pin 32*w+b. Bits for pins at or above the pin count read 0.
- R3: The first configuration word of pin n is at 0x100 + 8*n. Bit 31 is the output level and drives pin_out[n]. Bit 2 is the direction, with 1 meaning input and 0 meaning output. Bit 0 selects GPIO when 1 and native function when 0. All other bits except bit 30 read 0.
- R4: The second configuration word of pin n is at 0x104 + 8*n. Bit 2 set disables input sensing. Bits 1:0 are the pull code and appear on pin_pull[2n+1:2n]. All other bits read 0.
- R5: With sensing enabled, bit 30 of the first word reports pin_in[n] after a two-flop synchronizer. A change on the pin is visible in read data no later than the third rising edge after the change.
- R6: With sensing disabled, bit 30 reads 0 whatever the pin level. Re-enabling sensing shows the current level again.
- R7: pin_oe[n] is 1 only when own_map[n] is 1, bit 0 of the first word is 1 and bit 2 is 0. A pin that is not owned, or that is in native mode, never drives.
- R8: The global control word is at 0x7C. Bit 0 is writable and readable and drives irq_line_sel. The other bits read 0.
- R9: Writes to read-only bits are ignored. These are bit 30, the unused configuration bits and the ownership words. Addresses that are not word-aligned or not mapped read 0, and writes to them change nothing.
- R10: bus_rdata is registered. It presents the word addressed at the previous rising edge. If that edge also carried a write to the same word, the value shown is the one from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_we | input | 1 | Write enable for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| own_map | input | NPINS (94) | Preset ownership, 1 = pin usable as GPIO |
| pin_in | input | NPINS | Asynchronous pin input levels |
| pin_out | output | NPINS | Output level per pin |
| pin_oe | output | NPINS | Output enable per pin |
| pin_pull | output | 2*NPINS | Weak-pull code per pin, two bits each |
| irq_line_sel | output | 1 | Selects one of two interrupt lines |

## Verification
Most configuration state shows up at the ports one edge after a write. A wrong output-level, direction, select or ownership path shows at once as a wrong pin_out or pin_oe bit. Sense and pull faults show in read data and on pin_pull. A broken synchronizer or sense mask shows as a wrong bit 30 within three edges of a pin change. A decode slip shows as data landing in the wrong pin's word, or as non-zero reads from unmapped or unaligned addresses, on the first read of the affected address.

// File: rtl/gpio_pin_ctrl_pkg.sv
package gpio_pin_ctrl_pkg;

    localparam int DATA_W     = 32;
    localparam int OWN_BASE   = 'h000;
    localparam int GCTL_ADDR  = 'h07C;
    localparam int CFG_BASE   = 'h100;
    localparam int CFG_STRIDE = 8;

    // bit positions software relies on
    localparam int C1_OUT_BIT   = 31;
    localparam int C1_IN_BIT    = 30;
    localparam int C1_DIR_BIT   = 2;
    localparam int C1_USE_BIT   = 0;
    localparam int C2_NOSNS_BIT = 2;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_OWN,
        ACC_GCTL,
        ACC_CFG1,
        ACC_CFG2
    } acc_kind_e;

    typedef struct packed {
        logic       out_lvl;
        logic       dir_in;
        logic       use_gpio;
        logic       sense_off;
        logic [1:0] pull;
    } pin_cfg_t;

    localparam pin_cfg_t PIN_CFG_RST = '{
        out_lvl: 1'b0, dir_in: 1'b1, use_gpio: 1'b1, sense_off: 1'b1, pull: 2'b00
    };

    function automatic logic [DATA_W-1:0] pack_cfg1(input pin_cfg_t c, input logic in_lvl);
        logic [DATA_W-1:0] r;
        r = '0;
        r[C1_OUT_BIT] = c.out_lvl;
        r[C1_IN_BIT]  = in_lvl;
        r[C1_DIR_BIT] = c.dir_in;
        r[C1_USE_BIT] = c.use_gpio;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cfg2(input pin_cfg_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[C2_NOSNS_BIT] = c.sense_off;
        r[1:0]          = c.pull;
        return r;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pin_ctrl_pkg::*;
#(
    parameter int NPINS  = 94,
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam int NWORDS  = (NPINS + 31) / 32;
    localparam int OWN_END = OWN_BASE + NWORDS * 4;
    localparam int CFG_END = CFG_BASE + NPINS * CFG_STRIDE;

    int a;
    int off;

    always_comb begin
        a    = int'(addr);
        off  = a - CFG_BASE;
        kind = ACC_NONE;
        idx  = '0;
        if (addr[1:0] == 2'b00) begin
            if (a >= OWN_BASE && a < OWN_END) begin
                kind = ACC_OWN;
                idx  = IDX_W'((a - OWN_BASE) / 4);
            end else if (a == GCTL_ADDR) begin
                kind = ACC_GCTL;
            end else if (a >= CFG_BASE && a < CFG_END) begin
                kind = addr[2] ? ACC_CFG2 : ACC_CFG1;
                idx  = IDX_W'(off / CFG_STRIDE);
            end
        end
    end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_pin_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_cfg1,
    input  logic       wr_cfg2,
    input  logic       w_out,
    input  logic       w_dir,
    input  logic       w_use,
    input  logic       w_nosense,
    input  logic [1:0] w_pull,
    input  logic       owned,
    input  logic       pad_in,
    output pin_cfg_t   cfg_q,
    output logic       in_lvl,
    output logic       pad_out,
    output logic       pad_oe,
    output logic [1:0] pad_pull
);
    logic sync1_q, sync2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= PIN_CFG_RST;
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pad_in;
            sync2_q <= sync1_q;
            if (wr_cfg1) begin
                cfg_q.out_lvl  <= w_out;
                cfg_q.dir_in   <= w_dir;
                cfg_q.use_gpio <= w_use;
            end
            if (wr_cfg2) begin
                cfg_q.sense_off <= w_nosense;
                cfg_q.pull      <= w_pull;
            end
        end
    end

    assign in_lvl   = sync2_q & ~cfg_q.sense_off;
    assign pad_out  = cfg_q.out_lvl;
    assign pad_oe   = owned & cfg_q.use_gpio & ~cfg_q.dir_in;
    assign pad_pull = cfg_q.pull;
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pin_ctrl_pkg::*;
#(
    parameter int NPINS  = 94,
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NPINS-1:0]    own_map,
    input  logic [NPINS-1:0]    pin_in,
    output logic [NPINS-1:0]    pin_out,
    output logic [NPINS-1:0]    pin_oe,
    output logic [2*NPINS-1:0]  pin_pull,
    output logic                irq_line_sel
);
    localparam int NWORDS = (NPINS + 31) / 32;
    localparam int IDX_W  = (NPINS > NWORDS) ? $clog2(NPINS) : $clog2(NWORDS + 1);

    acc_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    pin_cfg_t          cfg_arr [NPINS];
    logic [NPINS-1:0]  lvl_vec;
    logic [NWORDS*32-1:0] own_pad;
    logic              gctl_q;
    logic [DATA_W-1:0] rd_next;
    logic [27:0]       unused_wdata;

    assign unused_wdata = bus_wdata[30:3];

    gpio_addr_dec #(.NPINS(NPINS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .idx  (idx)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic hit;
        assign hit = (idx == IDX_W'(i));
        gpio_pin_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .wr_cfg1   (bus_we && kind == ACC_CFG1 && hit),
            .wr_cfg2   (bus_we && kind == ACC_CFG2 && hit),
            .w_out     (bus_wdata[C1_OUT_BIT]),
            .w_dir     (bus_wdata[C1_DIR_BIT]),
            .w_use     (bus_wdata[C1_USE_BIT]),
            .w_nosense (bus_wdata[C2_NOSNS_BIT]),
            .w_pull    (bus_wdata[1:0]),
            .owned     (own_map[i]),
            .pad_in    (pin_in[i]),
            .cfg_q     (cfg_arr[i]),
            .in_lvl    (lvl_vec[i]),
            .pad_out   (pin_out[i]),
            .pad_oe    (pin_oe[i]),
            .pad_pull  (pin_pull[2*i +: 2])
        );
    end

    always_comb begin
        own_pad = '0;
        own_pad[NPINS-1:0] = own_map;
    end

    always_comb begin
        rd_next = '0;
        case (kind)
            ACC_OWN:  rd_next = own_pad[int'(idx)*32 +: 32];
            ACC_GCTL: rd_next = {{(DATA_W-1){1'b0}}, gctl_q};
            ACC_CFG1: rd_next = pack_cfg1(cfg_arr[idx], lvl_vec[idx]);
            ACC_CFG2: rd_next = pack_cfg2(cfg_arr[idx]);
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            gctl_q    <= 1'b0;
        end else begin
            bus_rdata <= rd_next;
            if (bus_we && kind == ACC_GCTL)
                gctl_q <= bus_wdata[0];
        end
    end

    assign irq_line_sel = gctl_q;
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk
    import gpio_pin_ctrl_pkg::*;
#(
    parameter int NPINS  = 94,
    parameter int ADDR_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic               wdata_msb,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NPINS-1:0]   own_map,
    input logic [NPINS-1:0]   pin_out,
    input logic [NPINS-1:0]   pin_oe
);
    // R7
    own_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & ~own_map) == '0);

    // R9
    unaligned_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0));

    // R2
    own_word0_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(OWN_BASE)) |=> (bus_rdata == $past(own_map[31:0])));

    // R3
    out_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(CFG_BASE)) |=> (pin_out[0] == $past(wdata_msb)));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(pin_out));
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .wdata_msb (bus_wdata[31]),
    .bus_rdata (bus_rdata),
    .own_map   (own_map),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/tb_gpio_pin_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_pin_ctrl;
    localparam int NP = 94;
    localparam int AW = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [AW-1:0]  addr = '0;
    logic           we = 1'b0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [NP-1:0]  own_map;
    logic [NP-1:0]  pin_in = '0;
    logic [NP-1:0]  pin_out, pin_oe;
    logic [2*NP-1:0] pin_pull;
    logic           line_sel;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    typedef struct {
        logic [31:0] exp;
        int          due;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gpio_pin_ctrl #(.NPINS(NP), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .own_map(own_map), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pull(pin_pull), .irq_line_sel(line_sel)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data when it falls due
    initial forever begin
        @(negedge clk);
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            chk(rdata, it.exp, it.tag);
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; we = 1'b0;
        sb.push_back('{exp: e, due: cyc + 1, tag: tag});
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wr_exp(input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        sb.push_back('{exp: e, due: cyc + 1, tag: tag});
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
        wait (sb.size() == 0);
    endtask

    initial begin
        #(200000 * 5);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        own_map = '1;
        own_map[5]  = 1'b0;
        own_map[40] = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(32'(pin_oe != '0), 32'd0, "R1 pin_oe");
        chk(32'(pin_out != '0), 32'd0, "R1 pin_out");
        chk(32'(line_sel), 32'd0, "R1 irq_line_sel");
        rd(12'h100, 32'h0000_0005, "R1 cfg1 pin0");
        rd(12'h3E8, 32'h0000_0005, "R1 cfg1 pin93");
        rd(12'h3EC, 32'h0000_0004, "R1 cfg2 pin93");
        rd(12'h07C, 32'h0000_0000, "R1 gctl");

        // R2 ownership words
        rd(12'h000, 32'hFFFF_FFDF, "R2 own word0");
        rd(12'h004, 32'hFFFF_FEFF, "R2 own word1");
        rd(12'h008, 32'h3FFF_FFFF, "R2 own word2 upper pins");
        wr(12'h000, 32'h0);
        rd(12'h000, 32'hFFFF_FFDF, "R9 own write ignored");
        settle();

        // R3 / R7 output pin 0
        wr(12'h100, 32'h8000_0001);
        chk(32'(pin_out[0]), 32'd1, "R3 pin_out0");
        chk(32'(pin_oe[0]), 32'd1, "R7 pin_oe0 driving");
        rd(12'h100, 32'h8000_0001, "R3 cfg1 pin0 readback");
        // R9 read-only bits of pin 1
        wr(12'h108, 32'hFFFF_FFFF);
        rd(12'h108, 32'h8000_0005, "R9 cfg1 pin1 ro bits");
        settle();
        chk(32'(pin_oe[1]), 32'd0, "R7 input pin1 no oe");
        // R7 not owned, native
        wr(12'h128, 32'h8000_0001);
        chk(32'(pin_oe[5]), 32'd0, "R7 unowned pin5");
        chk(32'(pin_out[5]), 32'd1, "R3 pin_out5");
        wr(12'h110, 32'h8000_0000);
        chk(32'(pin_oe[2]), 32'd0, "R7 native pin2");

        // R4 cfg2 pin 3
        wr(12'h11C, 32'hFFFF_FFF2);
        chk(32'(pin_pull[7:6]), 32'd2, "R4 pull pin3");
        rd(12'h11C, 32'h0000_0002, "R4 cfg2 pin3");
        settle();

        // R5 sensing on pin 3
        @(negedge clk);
        pin_in[3] = 1'b1;
        pin_in[4] = 1'b1;
        repeat (3) @(negedge clk);
        rd(12'h118, 32'h4000_0005, "R5 pin3 high");
        // R6 pin 4 sense off
        rd(12'h120, 32'h0000_0005, "R6 pin4 masked");
        settle();
        wr(12'h124, 32'h0);
        rd(12'h120, 32'h4000_0005, "R6 pin4 unmasked");
        settle();
        wr(12'h124, 32'h4);
        rd(12'h120, 32'h0000_0005, "R6 pin4 masked again");
        settle();
        @(negedge clk);
        pin_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        rd(12'h118, 32'h0000_0005, "R5 pin3 low");
        settle();

        // R8 global control
        wr(12'h07C, 32'hFFFF_FFFF);
        chk(32'(line_sel), 32'd1, "R8 irq_line_sel");
        rd(12'h07C, 32'h0000_0001, "R8 gctl readback");

        // R9 unmapped and unaligned
        rd(12'h102, 32'h0, "R9 unaligned read");
        rd(12'h3F0, 32'h0, "R9 past last pin");
        rd(12'h080, 32'h0, "R9 unmapped gap");
        settle();
        wr(12'h102, 32'h0);
        chk(32'(pin_out[0]), 32'd1, "R9 unaligned write ignored");

        // R10 read during write shows old value
        wr_exp(12'h100, 32'h0, 32'h8000_0001, "R10 old value");
        rd(12'h100, 32'h0000_0000, "R10 new value");
        settle();
        chk(32'(pin_oe[0]), 32'd0, "R7 pin0 native after write");
        chk(32'(pin_out[0]), 32'd0, "R3 pin0 level cleared");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule